// File: doc/BRIEF.md
# Block Lock Register Change Sequencer

This block moves the lock register of one flash block, held in a register space separate from the array, from its present value to a requested value. It first reads the register. It then applies at most three writes, each followed at once by a read-back that must confirm the step: the lockdown flag is cleared first, then the read-lock and write-lock flags are changed, and lockdown is set only at the end. The order matters because a device that honours lockdown refuses any other change once that flag is set. A request that would disturb bits beyond the three lock flags is refused before anything is written.

The block also has a walk mode that unlocks a run of equally sized blocks. Their lock registers lie at a fixed offset of 2 above a base address, one block size apart. The number of registers is the span divided by the block size. For each register the target value is its present value with both the read lock and the write lock cleared and the lockdown flag unchanged. The walk stops at the first block whose change fails and reports that block's index. The register bus is a plain synchronous port: a read strobe returns data one cycle later, and a write strobe carries its data in the same cycle.

Top module: `lock_change_seq`

## Requirements
- R1: Lock register fields: bit 0 is the write lock, bit 1 is the lockdown flag and bit 2 is the read lock. After reset `done`, `ok` and `err_code` are 0 and neither bus strobe is active.
- R2: A single change reads the register at `chg_addr` first. If the read value and `chg_value` differ in any bit above bit 2, the block ends with `err_code` 1 and writes nothing.
- R3: If the read value and `chg_value` agree in bits 0 to 2, the block ends with `ok` set, `err_code` 0 and no write.
- R4: If lockdown is set in the read value but not in the request, the first write is the read value with bit 1 cleared. If bit 1 is still set in the read-back, the block ends with `err_code` 2.
- R5: If bit 0 or bit 2 differs next, the block writes the present value with only bits 0 and 2 taken from the request. A read-back that differs from the written value in any bit ends the change with `err_code` 3.
- R6: Only after R4 and R5, if lockdown is requested and not set, the block writes the full requested value. A read-back that is not equal to the request ends the change with `err_code` 4.
- R7: Every write goes to the target address, keeps bits above bit 2 as read, and is followed in the next cycle by a read strobe to the same address.
- R8: `done` is a one-cycle pulse. For a single change it rises 3 + 4*W clock edges after the edge that samples `chg_start`, where W is the number of writes.
- R9: `walk_start` unlocks `walk_span >> BLK_SHIFT` registers, starting at `walk_base + 2` and stepping by `2**BLK_SHIFT`. Each register's target is its read value with bits 0 and 2 cleared.
- R10: A walk stops at the first failing block and reports its index on `fail_idx`. Later registers are not touched. A walk with zero blocks completes with `ok` on the edge that samples `walk_start` and makes no access.
- R11: At every `done` pulse, `ok` is 1 exactly when `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chg_start | input | 1 | Start a single change (takes priority over walk_start) |
| chg_addr | input | ADDR_W | Lock register address for a single change |
| chg_value | input | DATA_W | Requested lock register value |
| walk_start | input | 1 | Start an unlock walk |
| walk_base | input | ADDR_W | Register space base for the walk |
| walk_span | input | ADDR_W+1 | Total bytes covered by the walk |
| bus_addr | output | ADDR_W | Register bus address |
| bus_wdata | output | DATA_W | Register bus write data |
| bus_we | output | 1 | Register bus write strobe |
| bus_re | output | 1 | Register bus read strobe; data due one cycle later |
| bus_rdata | input | DATA_W | Register bus read data |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Last operation succeeded |
| err_code | output | 3 | 0 none, 1 bad request, 2 lockdown stuck, 3 lock bits not taken, 4 lockdown not taken |
| fail_idx | output | ADDR_W+1-BLK_SHIFT | Index of the failing block in a walk |

## Verification
The register model in the bench returns read data on the edge after the strobe. The sequencer therefore spends three edges to reach its first decision and four more for each write with its read-back. The bench counts edges from the one that samples the start to the first falling-edge sample where `done` is high, and compares the count with 3 + 4*W, where W is the number of writes for that case. Results, register contents and write counts are sampled in that same cycle. For a walk with zero blocks, `done` is expected in the cycle right after the start edge.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int WL_BIT = 0;
  localparam int LD_BIT = 1;
  localparam int RL_BIT = 2;

  typedef enum logic [2:0] {
    E_NONE    = 3'd0,
    E_BADREQ  = 3'd1,
    E_LDSTUCK = 3'd2,
    E_RWFAIL  = 3'd3,
    E_LDFAIL  = 3'd4
  } lcs_err_e;

  typedef enum logic [1:0] {
    PH_INIT  = 2'd0,
    PH_CLRLD = 2'd1,
    PH_RW    = 2'd2,
    PH_SETLD = 2'd3
  } lcs_phase_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_RD   = 3'd1,
    S_WT   = 3'd2,
    S_EV   = 3'd3,
    S_WR   = 3'd4,
    S_DONE = 3'd5
  } lcs_state_e;
endpackage

// File: rtl/lcs_planner.sv
module lcs_planner import lcs_pkg::*; #(
  parameter int DATA_W = 8
) (
  input  lcs_phase_e        phase,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] req,
  input  logic [DATA_W-1:0] want,
  output logic              fin,
  output lcs_err_e          fin_err,
  output logic [DATA_W-1:0] wr_data,
  output lcs_phase_e        nphase
);
  localparam logic [DATA_W-1:0] LOW_M = DATA_W'(7);
  localparam logic [DATA_W-1:0] RW_M  = DATA_W'(5);
  localparam logic [DATA_W-1:0] LD_M  = DATA_W'(2);

  logic [DATA_W-1:0] diff;
  logic try_clr, try_rw, try_set;

  assign diff = cur ^ req;

  // Candidate steps, only those not yet passed in the fixed order
  assign try_clr = (phase == PH_INIT) && cur[LD_BIT] && !req[LD_BIT];
  assign try_rw  = ((phase == PH_INIT) || (phase == PH_CLRLD)) &&
                   (diff[WL_BIT] || diff[RL_BIT]);
  assign try_set = (phase != PH_SETLD) && !cur[LD_BIT] && req[LD_BIT];

  always_comb begin
    fin     = 1'b0;
    fin_err = E_NONE;
    wr_data = cur;
    nphase  = phase;
    // Check the outcome of the step just read back
    case (phase)
      PH_INIT: begin
        if ((diff & ~LOW_M) != '0) begin
          fin     = 1'b1;
          fin_err = E_BADREQ;
        end else if ((diff & LOW_M) == '0) begin
          fin = 1'b1;
        end
      end
      PH_CLRLD: begin
        if (cur[LD_BIT]) begin
          fin     = 1'b1;
          fin_err = E_LDSTUCK;
        end
      end
      PH_RW: begin
        if (cur != want) begin
          fin     = 1'b1;
          fin_err = E_RWFAIL;
        end
      end
      default: begin
        fin = 1'b1;
        if (cur != want) fin_err = E_LDFAIL;
      end
    endcase
    // Pick the next step
    if (!fin) begin
      if (try_clr) begin
        wr_data = cur & ~LD_M;
        nphase  = PH_CLRLD;
      end else if (try_rw) begin
        wr_data = (cur & ~RW_M) | (req & RW_M);
        nphase  = PH_RW;
      end else if (try_set) begin
        wr_data = req;
        nphase  = PH_SETLD;
      end else begin
        fin = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcs_walker.sv
module lcs_walker #(
  parameter int ADDR_W    = 24,
  parameter int BLK_SHIFT = 16,
  parameter int LOCK_OFS  = 2,
  parameter int SPAN_W    = ADDR_W + 1,
  parameter int IDX_W     = SPAN_W - BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_one,
  input  logic [ADDR_W-1:0] one_addr,
  input  logic              load_walk,
  input  logic [ADDR_W-1:0] walk_base,
  input  logic [SPAN_W-1:0] walk_span,
  input  logic              adv,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx,
  output logic              last,
  output logic              span_empty
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(1) << BLK_SHIFT;
  localparam logic [ADDR_W-1:0] OFS    = ADDR_W'(LOCK_OFS);

  logic [IDX_W-1:0] count_q;

  assign span_empty = (walk_span[SPAN_W-1:BLK_SHIFT] == '0);
  assign last       = (idx == count_q - IDX_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr    <= '0;
      idx     <= '0;
      count_q <= '0;
    end else if (load_one) begin
      addr    <= one_addr;
      idx     <= '0;
      count_q <= IDX_W'(1);
    end else if (load_walk) begin
      addr    <= walk_base + OFS;
      idx     <= '0;
      count_q <= walk_span[SPAN_W-1:BLK_SHIFT];
    end else if (adv) begin
      addr <= addr + STRIDE;
      idx  <= idx + IDX_W'(1);
    end
  end
endmodule

// File: rtl/lock_change_seq.sv
module lock_change_seq import lcs_pkg::*; #(
  parameter int ADDR_W    = 24,
  parameter int DATA_W    = 8,
  parameter int BLK_SHIFT = 16,
  parameter int LOCK_OFS  = 2,
  localparam int SPAN_W   = ADDR_W + 1,
  localparam int IDX_W    = SPAN_W - BLK_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chg_start,
  input  logic [ADDR_W-1:0] chg_addr,
  input  logic [DATA_W-1:0] chg_value,
  input  logic              walk_start,
  input  logic [ADDR_W-1:0] walk_base,
  input  logic [SPAN_W-1:0] walk_span,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              done,
  output logic              ok,
  output logic [2:0]        err_code,
  output logic [IDX_W-1:0]  fail_idx
);
  localparam logic [DATA_W-1:0] RW_M = DATA_W'(5);

  lcs_state_e        st_q, st_d;
  lcs_phase_e        ph_q, ph_d;
  logic              walk_q, walk_d;
  logic [DATA_W-1:0] cur_q, req_q, req_d, want_q, want_d;
  lcs_err_e          res_d;
  logic              load_one, load_walk, adv;
  logic [IDX_W-1:0]  wk_idx;
  logic              wk_last, wk_empty;
  logic              pl_fin;
  lcs_err_e          pl_err;
  logic [DATA_W-1:0] pl_wdata;
  lcs_phase_e        pl_phase;

  lcs_planner #(.DATA_W(DATA_W)) u_plan (
    .phase(ph_q), .cur(cur_q), .req(req_q), .want(want_q),
    .fin(pl_fin), .fin_err(pl_err), .wr_data(pl_wdata), .nphase(pl_phase)
  );

  lcs_walker #(
    .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT), .LOCK_OFS(LOCK_OFS),
    .SPAN_W(SPAN_W), .IDX_W(IDX_W)
  ) u_walk (
    .clk(clk), .rst(rst),
    .load_one(load_one), .one_addr(chg_addr),
    .load_walk(load_walk), .walk_base(walk_base), .walk_span(walk_span),
    .adv(adv), .addr(bus_addr), .idx(wk_idx), .last(wk_last),
    .span_empty(wk_empty)
  );

  always_comb begin
    st_d      = st_q;
    ph_d      = ph_q;
    walk_d    = walk_q;
    req_d     = req_q;
    want_d    = want_q;
    res_d     = E_NONE;
    load_one  = 1'b0;
    load_walk = 1'b0;
    adv       = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (chg_start) begin
          load_one = 1'b1;
          walk_d   = 1'b0;
          ph_d     = PH_INIT;
          req_d    = chg_value;
          st_d     = S_RD;
        end else if (walk_start) begin
          load_walk = 1'b1;
          walk_d    = 1'b1;
          ph_d      = PH_INIT;
          st_d      = wk_empty ? S_DONE : S_RD;
        end
      end
      S_RD: st_d = S_WT;
      S_WT: begin
        if (walk_q && (ph_q == PH_INIT)) req_d = bus_rdata & ~RW_M;
        st_d = S_EV;
      end
      S_EV: begin
        if (!pl_fin) begin
          want_d = pl_wdata;
          ph_d   = pl_phase;
          st_d   = S_WR;
        end else if (pl_err != E_NONE) begin
          res_d = pl_err;
          st_d  = S_DONE;
        end else if (walk_q && !wk_last) begin
          adv  = 1'b1;
          ph_d = PH_INIT;
          st_d = S_RD;
        end else begin
          st_d = S_DONE;
        end
      end
      S_WR:    st_d = S_RD;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= S_IDLE;
      ph_q      <= PH_INIT;
      walk_q    <= 1'b0;
      cur_q     <= '0;
      req_q     <= '0;
      want_q    <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      bus_wdata <= '0;
      done      <= 1'b0;
      ok        <= 1'b0;
      err_code  <= 3'd0;
      fail_idx  <= '0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      walk_q <= walk_d;
      req_q  <= req_d;
      want_q <= want_d;
      if (st_q == S_WT) cur_q <= bus_rdata;
      bus_we <= (st_d == S_WR);
      bus_re <= (st_d == S_RD);
      if (st_d == S_WR) bus_wdata <= pl_wdata;
      done <= (st_d == S_DONE);
      if (st_d == S_DONE) begin
        ok       <= (res_d == E_NONE);
        err_code <= res_d;
        fail_idx <= (walk_d && (res_d != E_NONE)) ? wk_idx : '0;
      end
    end
  end
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              chg_start,
  input logic              walk_start,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              done,
  input logic              ok,
  input logic [2:0]        err_code
);
  localparam logic [DATA_W-1:0] LOW_M = DATA_W'(7);

  logic              rd_pend;
  logic [DATA_W-1:0] last_rd;
  logic              wrote;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend <= 1'b0;
      last_rd <= '0;
      wrote   <= 1'b0;
    end else begin
      rd_pend <= bus_re;
      if (rd_pend) last_rd <= bus_rdata;
      if (chg_start || walk_start) wrote <= 1'b0;
      else if (bus_we) wrote <= 1'b1;
    end
  end

  // R7: read-back of the same address right after each write
  a_r7_readback: assert property (@(posedge clk) disable iff (rst)
    bus_we |=> (bus_re && bus_addr == $past(bus_addr)));

  // R7: bits above the lock field keep the value read
  a_r7_upper_kept: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> (((bus_wdata ^ last_rd) & ~LOW_M) == '0));

  // R6: setting lockdown never changes the read/write locks in the same write
  a_r6_ld_last: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_wdata[1] && !last_rd[1]) |->
      (bus_wdata[0] == last_rd[0] && bus_wdata[2] == last_rd[2]));

  // R4: clearing lockdown changes nothing else
  a_r4_ld_first: assert property (@(posedge clk) disable iff (rst)
    (bus_we && !bus_wdata[1] && last_rd[1]) |->
      (bus_wdata[0] == last_rd[0] && bus_wdata[2] == last_rd[2]));

  // R2: a refused request wrote nothing
  a_r2_bad_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && err_code == 3'd1) |-> !wrote);

  // R8: done lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: ok agrees with the error code
  a_r11_ok_code: assert property (@(posedge clk) disable iff (rst)
    done |-> (ok == (err_code == 3'd0)));

  a_r7_strobe_excl: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_re));
endmodule

bind lock_change_seq lcs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .chg_start(chg_start), .walk_start(walk_start),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .done(done), .ok(ok),
  .err_code(err_code)
);

// File: tb/tb_lock_change_seq.sv
`timescale 1ns/1ps
module tb_lock_change_seq;
  localparam int AW  = 12;
  localparam int DW  = 8;
  localparam int BS  = 6;
  localparam int IW  = AW + 1 - BS;
  localparam int NV  = 14;

  // {init[30:23], req[22:15], flags[14:13], err[12:10], final[9:2], writes[1:0]}
  // flags bit0: lockdown sticky, bit1: lockdown cannot be set
  localparam logic [30:0] VEC [0:NV-1] = '{
    {8'h01, 8'h00, 2'd0, 3'd0, 8'h00, 2'd1},
    {8'h01, 8'h01, 2'd0, 3'd0, 8'h01, 2'd0},
    {8'h01, 8'h09, 2'd0, 3'd1, 8'h01, 2'd0},
    {8'h02, 8'h00, 2'd0, 3'd0, 8'h00, 2'd1},
    {8'h02, 8'h00, 2'd1, 3'd2, 8'h02, 2'd1},
    {8'h00, 8'h07, 2'd0, 3'd0, 8'h07, 2'd2},
    {8'h00, 8'h07, 2'd2, 3'd4, 8'h05, 2'd2},
    {8'h03, 8'h06, 2'd0, 3'd0, 8'h06, 2'd1},
    {8'h03, 8'h06, 2'd1, 3'd3, 8'h03, 2'd1},
    {8'h07, 8'h00, 2'd0, 3'd0, 8'h00, 2'd2},
    {8'h05, 8'h02, 2'd0, 3'd0, 8'h02, 2'd2},
    {8'hF1, 8'hF0, 2'd0, 3'd0, 8'hF0, 2'd1},
    {8'hF1, 8'h71, 2'd0, 3'd1, 8'hF1, 2'd0},
    {8'h06, 8'h02, 2'd2, 3'd0, 8'h02, 2'd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chg_start = 1'b0, walk_start = 1'b0;
  logic [AW-1:0] chg_addr = '0, walk_base = '0;
  logic [DW-1:0] chg_value = '0;
  logic [AW:0]   walk_span = '0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_we, bus_re, done, ok;
  logic [2:0] err_code;
  logic [IW-1:0] fail_idx;

  int checks = 0, errors = 0;
  logic [DW-1:0] regs [0:(1<<AW)-1];
  logic sticky = 1'b0, no_ldset = 1'b0;
  int wr_cnt = 0, stray = 0;
  logic [AW-1:0] tgt = '0;
  logic chk_stray = 1'b0;

  always #2 clk = ~clk;

  lock_change_seq #(.ADDR_W(AW), .DATA_W(DW), .BLK_SHIFT(BS)) dut (
    .clk(clk), .rst(rst), .chg_start(chg_start), .chg_addr(chg_addr),
    .chg_value(chg_value), .walk_start(walk_start), .walk_base(walk_base),
    .walk_span(walk_span), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .done(done),
    .ok(ok), .err_code(err_code), .fail_idx(fail_idx)
  );

  // Register space model: one-cycle read latency
  always @(posedge clk) begin
    if (bus_re) bus_rdata <= regs[bus_addr];
    if (bus_we) begin
      logic [DW-1:0] o, n;
      o = regs[bus_addr];
      n = bus_wdata;
      if (sticky && o[1]) n = o;
      if (no_ldset && !o[1]) n[1] = 1'b0;
      regs[bus_addr] <= n;
      wr_cnt <= wr_cnt + 1;
      if (chk_stray && bus_addr != tgt) stray <= stray + 1;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk("R8 done never seen", 0, 1);
  endtask

  function automatic string tag_of(logic [2:0] e, logic [1:0] w);
    case (e)
      3'd1: return "R2";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return (w == 2'd0) ? "R3" : "R5 R6 success";
    endcase
  endfunction

  task automatic run_vec(logic [30:0] v, int n);
    int lat;
    string t;
    t = tag_of(v[12:10], v[1:0]);
    sticky   = v[13];
    no_ldset = v[14];
    tgt      = AW'(12'h040 + n);
    regs[tgt] = v[30:23];
    wr_cnt = 0; stray = 0; chk_stray = 1'b1;
    @(negedge clk);
    chg_start = 1'b1; chg_addr = tgt; chg_value = v[22:15];
    @(negedge clk);
    chg_start = 1'b0;
    wait_done(lat);
    chk($sformatf("%s err case %0d", t, n), 32'(err_code), 32'(v[12:10]));
    chk($sformatf("%s final value case %0d", t, n), 32'(regs[tgt]), 32'(v[9:2]));
    chk($sformatf("%s writes case %0d", t, n), 32'(wr_cnt), 32'(v[1:0]));
    chk($sformatf("R11 ok case %0d", n), 32'(ok), 32'(v[12:10] == 3'd0));
    chk($sformatf("R8 latency case %0d", n), 32'(lat), 32'(3 + 4 * v[1:0]));
    chk($sformatf("R7 stray writes case %0d", n), 32'(stray), 0);
    @(negedge clk);
    chk($sformatf("R8 pulse case %0d", n), 32'(done), 0);
    chk_stray = 1'b0;
  endtask

  task automatic load_walk_regs();
    regs[12'h102] = 8'h01;
    regs[12'h142] = 8'h03;
    regs[12'h182] = 8'h01;
    regs[12'h1C2] = 8'h05;
    regs[12'h202] = 8'h05;
  endtask

  initial begin
    int lat;
    for (int i = 0; i < (1 << AW); i++) regs[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset ok", 32'(ok), 0);
    chk("R1 reset err", 32'(err_code), 0);
    chk("R1 reset strobes", 32'({bus_we, bus_re}), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R9: full walk over four blocks, all succeed
    sticky = 1'b0; no_ldset = 1'b0;
    load_walk_regs();
    regs[12'h182] = 8'h00;
    @(negedge clk);
    walk_start = 1'b1; walk_base = 12'h100; walk_span = 13'h100;
    @(negedge clk);
    walk_start = 1'b0;
    wait_done(lat);
    chk("R9 walk ok", 32'(ok), 1);
    chk("R9 block0", 32'(regs[12'h102]), 32'h00);
    chk("R9 block1 lockdown kept", 32'(regs[12'h142]), 32'h02);
    chk("R9 block2", 32'(regs[12'h182]), 32'h00);
    chk("R9 block3", 32'(regs[12'h1C2]), 32'h00);
    chk("R9 beyond span untouched", 32'(regs[12'h202]), 32'h05);

    // R10: walk stops at block 1 when lockdown freezes it
    sticky = 1'b1;
    load_walk_regs();
    @(negedge clk);
    walk_start = 1'b1;
    @(negedge clk);
    walk_start = 1'b0;
    wait_done(lat);
    chk("R10 walk err", 32'(err_code), 3);
    chk("R10 walk ok low", 32'(ok), 0);
    chk("R10 fail index", 32'(fail_idx), 1);
    chk("R10 block0 done", 32'(regs[12'h102]), 32'h00);
    chk("R10 block2 untouched", 32'(regs[12'h182]), 32'h01);
    chk("R10 block3 untouched", 32'(regs[12'h1C2]), 32'h05);

    // R10: zero-block walk
    sticky = 1'b0;
    wr_cnt = 0;
    @(negedge clk);
    walk_start = 1'b1; walk_span = 13'h020;
    @(negedge clk);
    walk_start = 1'b0;
    wait_done(lat);
    chk("R10 empty walk latency", 32'(lat), 0);
    chk("R10 empty walk ok", 32'(ok), 1);
    chk("R10 empty walk no write", 32'(wr_cnt), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule